// File: doc/BRIEF.md
# One-Wire Bus Master

This block lets a host drive a single open-drain one-wire data line through five byte-wide registers. The host can start a bus reset with a presence check, send a byte as eight time slots with the least significant bit first, and collect the byte the line carried during those slots. Each slot samples the line after the master drives its own bit. A byte written as 0xFF therefore leaves the line free for the slave, so the value read back is the slave's byte. Status flags report the transmit buffer, the transmit shift register, the receive buffer, a second receive stage and the presence result. An interrupt output combines the enabled flags, and its polarity is programmable.

The block does not generate its timing from the system clock. All slot and reset timing is counted in pulses of a 1 MHz `tick_us` input, which a separate divider produces. The divider setting is held in a register of this block and is driven out on `clk_div`. The line is driven through `owire_oe`, where 1 pulls the line low. The line level comes back on `owire_in`.

Top module: `owm_master`

## Requirements
- R1: The register offsets are command=0, data=1, status=2, enable=3 and divisor=4. Each offset is shifted left by `ADDR_SHIFT` to give its host address (default 1, so addresses 0, 2, 4, 6 and 8). A read from any other address returns 0, and a write to any other address changes nothing.
- R2: Writing command bit0=1 starts a bus reset. The line is held low for 480 ticks and then released for 480 ticks. The line is sampled 70 ticks after release. At that sample, status bit0 (presence done) is set, and status bit1 records the line level: 1 means no device answered, 0 means a device is present. Command bit0 reads 1 while a reset is pending or running.
- R3: Writing the data register sends the byte in eight slots, least significant bit first. A 1 bit holds the line low for 6 ticks and a 0 bit holds it low for 60 ticks. Each slot lasts 60 ticks and is followed by a 2-tick released gap.
- R4: Each slot samples the line 15 ticks after the slot starts. The received byte equals the transmitted byte ANDed with the bits the slave pulls low. At the end of the byte it is placed in the receive buffer (read at the data address) and status bit4 is set. Reading the data register clears status bit4.
- R5: If a byte completes while status bit4 is still set, the byte is held in a second stage and status bit5 is set. The next data read returns the older byte, moves the held byte up, clears bit5 and leaves bit4 set.
- R6: Status bit2 (transmit buffer empty) goes to 0 when the data register is written and returns to 1 when the slot engine takes the byte. Status bit3 (shift register empty) is 0 from that point until all eight slots and gaps have finished. After reset the status reads 0x0C.
- R7: Reading the status register clears bit0 and leaves every other status bit unchanged.
- R8: The interrupt output is active when any status bit among 0, 2, 3, 4 and 5 is set together with the enable bit at the same position. Enable bit1=1 makes the output active-high; enable bit1=0 makes it active-low.
- R9: Command bit2 pulls the line low only while enable bit6 is 1. Command bit2 reads back as 0. Command bit3 reads back the synchronised line level.
- R10: Writing command bit5=1 returns every register, flag and the slot engine to the reset state, and releases the line on the next cycle.
- R11: A pending reset request is served before a pending transmit byte. The byte waits in the buffer, with status bit2=0, until the reset sequence ends.
- R12: The divisor register keeps the low 5 bits written to it, reads them back, and drives them on `clk_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| host_addr | input | ADDR_W | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; data is valid the following cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| owire_in | input | 1 | Level sensed on the one-wire line |
| owire_oe | output | 1 | 1 pulls the line low |
| irq | output | 1 | Interrupt, polarity set by enable bit1 |
| clk_div | output | DIV_W | Divisor setting for the external tick divider |

## Verification
The bench models a slave that answers reset pulses with a presence pulse and pulls the line low for the 0 bits of a chosen byte. It sends random bytes against random slave bytes and measures every low pulse in ticks. A wrong sampling point would return the transmitted byte instead of the AND of both bytes, and swapped slot widths would show up as 6-tick versus 60-tick mismatches. Directed cases target the harder orderings:
- Two bytes arrive with no read between them. A design without the second stage would lose or overwrite the first byte.
- A reset is requested just before a byte is written. A design without the priority rule would start the slots first.
- A forced-low request is made with its enable bit clear. A design without the gate would pull the line low.
- A software reset is issued mid-slot. A design that misses it would keep the line low.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_RST_LOW,
    ENG_RST_REC,
    ENG_SLOT,
    ENG_GAP
  } eng_state_e;

  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_DATA = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_IEN  = 3;
  localparam int unsigned OFS_DIV  = 4;

  localparam int unsigned CMD_RESET = 0;
  localparam int unsigned CMD_FORCE = 2;
  localparam int unsigned CMD_SWRST = 5;
  localparam int unsigned IEN_POL   = 1;
  localparam int unsigned IEN_FORCE = 6;

endpackage

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int unsigned T_RST_LOW   = 480,
  parameter int unsigned T_RST_HIGH  = 480,
  parameter int unsigned T_PD_SAMPLE = 70,
  parameter int unsigned T_LOW1      = 6,
  parameter int unsigned T_LOW0      = 60,
  parameter int unsigned T_SAMPLE    = 15,
  parameter int unsigned T_SLOT      = 60,
  parameter int unsigned T_GAP       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       line_i,
  input  logic       start_rst,
  input  logic       start_byte,
  input  logic [7:0] tx_byte,
  output logic       idle_o,
  output logic       byte_busy_o,
  output logic       rst_busy_o,
  output logic       pres_valid_o,
  output logic       pres_absent_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       oe_o
);

  localparam int unsigned T_MAX = (T_RST_LOW > T_RST_HIGH) ? T_RST_LOW : T_RST_HIGH;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [7:0]        shift_q, shift_n;
  logic [7:0]        rx_q, rx_n;
  logic [2:0]        bit_q, bit_n;
  logic              oe_q, oe_n;
  logic              pres_valid, byte_done;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    shift_n    = shift_q;
    rx_n       = rx_q;
    bit_n      = bit_q;
    pres_valid = 1'b0;
    byte_done  = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start_rst) begin
          state_n = ENG_RST_LOW;
          cnt_n   = '0;
        end else if (start_byte) begin
          state_n = ENG_SLOT;
          cnt_n   = '0;
          shift_n = tx_byte;
          bit_n   = '0;
        end
      end
      ENG_RST_LOW: begin
        if (tick) begin
          if (cnt_q == CNT_W'(T_RST_LOW - 1)) begin
            state_n = ENG_RST_REC;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ENG_RST_REC: begin
        if (tick) begin
          if (cnt_q == CNT_W'(T_PD_SAMPLE - 1)) pres_valid = 1'b1;
          if (cnt_q == CNT_W'(T_RST_HIGH - 1)) begin
            state_n = ENG_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ENG_SLOT: begin
        if (tick) begin
          if (cnt_q == CNT_W'(T_SAMPLE - 1)) rx_n = {line_i, rx_q[7:1]};
          if (cnt_q == CNT_W'(T_SLOT - 1)) begin
            state_n = ENG_GAP;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          if (cnt_q == CNT_W'(T_GAP - 1)) begin
            cnt_n = '0;
            if (bit_q == 3'd7) begin
              state_n   = ENG_IDLE;
              byte_done = 1'b1;
            end else begin
              bit_n   = bit_q + 1'b1;
              shift_n = {1'b0, shift_q[7:1]};
              state_n = ENG_SLOT;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = ENG_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      ENG_RST_LOW: oe_n = 1'b1;
      ENG_SLOT:    oe_n = shift_n[0] ? (cnt_n < CNT_W'(T_LOW1)) : (cnt_n < CNT_W'(T_LOW0));
      default:     oe_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (clr) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      shift_q <= shift_n;
      rx_q    <= rx_n;
      bit_q   <= bit_n;
      oe_q    <= oe_n;
    end
  end

  assign idle_o        = (state_q == ENG_IDLE);
  assign byte_busy_o   = (state_q == ENG_SLOT) || (state_q == ENG_GAP);
  assign rst_busy_o    = (state_q == ENG_RST_LOW) || (state_q == ENG_RST_REC);
  assign pres_valid_o  = pres_valid;
  assign pres_absent_o = line_i;
  assign byte_done_o   = byte_done;
  assign rx_byte_o     = rx_q;
  assign oe_o          = oe_q;

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (byte_done && !clr) |=> (state_q == ENG_IDLE)); // R3
  AST_RST_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) ((state_q == ENG_RST_LOW) && $past(state_q == ENG_RST_LOW)) |-> oe_q); // R2
  AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) ((state_q == ENG_GAP) && $past(state_q == ENG_GAP)) |-> !oe_q); // R3

endmodule

// File: rtl/owm_regs.sv
module owm_regs
  import owm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ADDR_SHIFT = 1,
  parameter int unsigned DIV_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              line_s,
  input  logic              eng_idle,
  input  logic              eng_byte_busy,
  input  logic              eng_rst_busy,
  input  logic              pres_valid,
  input  logic              pres_absent,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              start_rst,
  output logic              start_byte,
  output logic [7:0]        tx_byte,
  output logic              soft_clr,
  output logic              force_low,
  output logic              irq_o,
  output logic [DIV_W-1:0]  clk_div_o
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD  << ADDR_SHIFT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA << ADDR_SHIFT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT << ADDR_SHIFT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN  << ADDR_SHIFT);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV  << ADDR_SHIFT);

  logic sel_cmd, sel_data, sel_stat, sel_ien, sel_div;
  logic wr_cmd, wr_data, wr_ien, wr_div, rd_data, rd_stat;

  logic             rst_req_q, rst_req_n;
  logic             force_q, force_n;
  logic [6:0]       ien_q, ien_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [7:0]       txbuf_q, txbuf_n;
  logic             tbe_q, tbe_n;
  logic [7:0]       rxbuf_q, rxbuf_n;
  logic             rbf_q, rbf_n;
  logic [7:0]       rxsh_q, rxsh_n;
  logic             rsrf_q, rsrf_n;
  logic             pd_q, pd_n;
  logic             pdr_q, pdr_n;
  logic [7:0]       rdata_q, rdata_n;
  logic [7:0]       rd_val;
  logic [7:0]       status;
  logic [5:0]       irq_src;
  logic             tsre, irq_act;

  assign sel_cmd  = (host_addr == A_CMD);
  assign sel_data = (host_addr == A_DATA);
  assign sel_stat = (host_addr == A_STAT);
  assign sel_ien  = (host_addr == A_IEN);
  assign sel_div  = (host_addr == A_DIV);

  assign wr_cmd   = host_wr && sel_cmd;
  assign wr_data  = host_wr && sel_data;
  assign wr_ien   = host_wr && sel_ien;
  assign wr_div   = host_wr && sel_div;
  assign rd_data  = host_rd && sel_data;
  assign rd_stat  = host_rd && sel_stat;
  assign soft_clr = wr_cmd && host_wdata[CMD_SWRST];

  assign start_rst  = rst_req_q && eng_idle;
  assign start_byte = !tbe_q && eng_idle && !rst_req_q;
  assign tsre       = !eng_byte_busy && tbe_q;

  assign status  = {2'b00, rsrf_q, rbf_q, tsre, tbe_q, pdr_q, pd_q};
  assign irq_src = status[5:0] & {ien_q[5:2], 1'b0, ien_q[0]};
  assign irq_act = |irq_src;
  assign irq_o   = ien_q[IEN_POL] ? irq_act : !irq_act;

  always_comb begin
    rd_val = '0;
    if (sel_cmd)       rd_val = {4'b0000, line_s, 2'b00, rst_req_q || eng_rst_busy};
    else if (sel_data) rd_val = rxbuf_q;
    else if (sel_stat) rd_val = status;
    else if (sel_ien)  rd_val = {1'b0, ien_q};
    else if (sel_div)  rd_val = 8'(div_q);
  end

  always_comb begin
    rst_req_n = rst_req_q;
    force_n   = force_q;
    ien_n     = ien_q;
    div_n     = div_q;
    txbuf_n   = txbuf_q;
    tbe_n     = tbe_q;
    rxbuf_n   = rxbuf_q;
    rbf_n     = rbf_q;
    rxsh_n    = rxsh_q;
    rsrf_n    = rsrf_q;
    pd_n      = pd_q;
    pdr_n     = pdr_q;
    rdata_n   = host_rd ? rd_val : rdata_q;

    if (start_rst) rst_req_n = 1'b0;
    if (wr_cmd) begin
      force_n = host_wdata[CMD_FORCE];
      if (host_wdata[CMD_RESET]) rst_req_n = 1'b1;
    end
    if (wr_ien) ien_n = host_wdata[6:0];
    if (wr_div) div_n = host_wdata[DIV_W-1:0];

    if (start_byte) tbe_n = 1'b1;
    if (wr_data) begin
      txbuf_n = host_wdata;
      tbe_n   = 1'b0;
    end

    if (rd_data) begin
      if (rsrf_q) begin
        rxbuf_n = rxsh_q;
        rsrf_n  = 1'b0;
      end else begin
        rbf_n = 1'b0;
      end
    end
    if (byte_done) begin
      if (!rbf_n) begin
        rxbuf_n = rx_byte;
        rbf_n   = 1'b1;
      end else begin
        rxsh_n = rx_byte;
        rsrf_n = 1'b1;
      end
    end

    if (rd_stat) pd_n = 1'b0;
    if (pres_valid) begin
      pd_n  = 1'b1;
      pdr_n = pres_absent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      force_q   <= 1'b0;
      ien_q     <= '0;
      div_q     <= '0;
      txbuf_q   <= '0;
      tbe_q     <= 1'b1;
      rxbuf_q   <= '0;
      rbf_q     <= 1'b0;
      rxsh_q    <= '0;
      rsrf_q    <= 1'b0;
      pd_q      <= 1'b0;
      pdr_q     <= 1'b0;
      rdata_q   <= '0;
    end else if (soft_clr) begin
      rst_req_q <= 1'b0;
      force_q   <= 1'b0;
      ien_q     <= '0;
      div_q     <= '0;
      txbuf_q   <= '0;
      tbe_q     <= 1'b1;
      rxbuf_q   <= '0;
      rbf_q     <= 1'b0;
      rxsh_q    <= '0;
      rsrf_q    <= 1'b0;
      pd_q      <= 1'b0;
      pdr_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rst_req_q <= rst_req_n;
      force_q   <= force_n;
      ien_q     <= ien_n;
      div_q     <= div_n;
      txbuf_q   <= txbuf_n;
      tbe_q     <= tbe_n;
      rxbuf_q   <= rxbuf_n;
      rbf_q     <= rbf_n;
      rxsh_q    <= rxsh_n;
      rsrf_q    <= rsrf_n;
      pd_q      <= pd_n;
      pdr_q     <= pdr_n;
      rdata_q   <= rdata_n;
    end
  end

  assign host_rdata = rdata_q;
  assign tx_byte    = txbuf_q;
  assign force_low  = force_q && ien_q[IEN_FORCE];
  assign clk_div_o  = div_q;

  AST_SECOND_STAGE_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n) rsrf_q |-> rbf_q); // R5
  AST_PD_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_stat && !pres_valid) |=> !pd_q); // R7
  AST_DATA_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr_data |=> !tbe_q); // R6
  AST_RBF_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rbf_q) |-> $past(byte_done)); // R4
  AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n) soft_clr |=> (tbe_q && !rbf_q && !rsrf_q && (ien_q == '0))); // R10

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned ADDR_SHIFT  = 1,
  parameter int unsigned DIV_W       = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned T_RST_LOW   = 480,
  parameter int unsigned T_RST_HIGH  = 480,
  parameter int unsigned T_PD_SAMPLE = 70,
  parameter int unsigned T_LOW1      = 6,
  parameter int unsigned T_LOW0      = 60,
  parameter int unsigned T_SAMPLE    = 15,
  parameter int unsigned T_SLOT      = 60,
  parameter int unsigned T_GAP       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              owire_in,
  output logic              owire_oe,
  output logic              irq,
  output logic [DIV_W-1:0]  clk_div
);

  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic [SYNC_STAGES-1:0] line_sync_q;
  logic                   line_s;

  logic       eng_idle, eng_byte_busy, eng_rst_busy;
  logic       pres_valid, pres_absent, byte_done;
  logic [7:0] rx_byte, tx_byte;
  logic       start_rst, start_byte, soft_clr, force_low, eng_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) line_sync_q <= '1;
    else            line_sync_q <= {line_sync_q[SYNC_STAGES-2:0], owire_in};
  end
  assign line_s = line_sync_q[SYNC_STAGES-1];

  owm_regs #(
    .ADDR_W     (ADDR_W),
    .ADDR_SHIFT (ADDR_SHIFT),
    .DIV_W      (DIV_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .line_s        (line_s),
    .eng_idle      (eng_idle),
    .eng_byte_busy (eng_byte_busy),
    .eng_rst_busy  (eng_rst_busy),
    .pres_valid    (pres_valid),
    .pres_absent   (pres_absent),
    .byte_done     (byte_done),
    .rx_byte       (rx_byte),
    .start_rst     (start_rst),
    .start_byte    (start_byte),
    .tx_byte       (tx_byte),
    .soft_clr      (soft_clr),
    .force_low     (force_low),
    .irq_o         (irq),
    .clk_div_o     (clk_div)
  );

  owm_slot_engine #(
    .T_RST_LOW   (T_RST_LOW),
    .T_RST_HIGH  (T_RST_HIGH),
    .T_PD_SAMPLE (T_PD_SAMPLE),
    .T_LOW1      (T_LOW1),
    .T_LOW0      (T_LOW0),
    .T_SAMPLE    (T_SAMPLE),
    .T_SLOT      (T_SLOT),
    .T_GAP       (T_GAP)
  ) u_engine (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .clr           (soft_clr),
    .tick          (tick_us),
    .line_i        (line_s),
    .start_rst     (start_rst),
    .start_byte    (start_byte),
    .tx_byte       (tx_byte),
    .idle_o        (eng_idle),
    .byte_busy_o   (eng_byte_busy),
    .rst_busy_o    (eng_rst_busy),
    .pres_valid_o  (pres_valid),
    .pres_absent_o (pres_absent),
    .byte_done_o   (byte_done),
    .rx_byte_o     (rx_byte),
    .oe_o          (eng_oe)
  );

  assign owire_oe = eng_oe || force_low;

  AST_SWRST_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_int_n) soft_clr |=> !owire_oe); // R10
  AST_RESET_BEFORE_BYTE: assert property (@(posedge clk) disable iff (!rst_int_n) (start_rst && start_byte) |-> 1'b0); // R11

endmodule

// File: tb/owm_master_bench.sv
module owm_master_bench;

  localparam int SHIFT = 1;
  localparam int AW    = 5;
  localparam int DW    = 5;
  localparam int TDIV  = 4;

  logic          clk;
  logic          rst_n;
  logic          tick_us;
  logic [AW-1:0] host_addr;
  logic          host_wr;
  logic          host_rd;
  logic [7:0]    host_wdata;
  logic [7:0]    host_rdata;
  logic          owire_in;
  logic          owire_oe;
  logic          irq;
  logic [DW-1:0] clk_div;

  int n_checks = 0;
  int n_err    = 0;

  owm_master #(.ADDR_W(AW), .ADDR_SHIFT(SHIFT), .DIV_W(DW)) u_owm_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .owire_in   (owire_in),
    .owire_oe   (owire_oe),
    .irq        (irq),
    .clk_div    (clk_div)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tdiv_cnt = 0;
  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick_us  <= (tdiv_cnt == TDIV - 2);
  end

  // slave model and low-pulse monitor
  logic [7:0] sl_byte    = 8'hFF;
  logic       sl_present = 1'b0;
  logic [7:0] cur_byte   = 8'hFF;
  int  bit_idx    = 8;
  int  pull_ticks = 0;
  int  pd_delay   = 0;
  int  low_ticks  = 0;
  int  lw_n       = 0;
  int  lw [0:15];
  logic oe_d = 1'b0;

  assign owire_in = !owire_oe && (pull_ticks == 0);

  always @(posedge clk) begin
    oe_d <= owire_oe;
    if (tick_us) begin
      if (pull_ticks > 0) pull_ticks <= pull_ticks - 1;
      if (pd_delay > 0) begin
        pd_delay <= pd_delay - 1;
        if (pd_delay == 1) pull_ticks <= 100;
      end
      if (owire_oe) low_ticks <= low_ticks + 1;
    end
    if (owire_oe && !oe_d) begin
      low_ticks <= 0;
      if (bit_idx < 8) begin
        if (!cur_byte[bit_idx]) pull_ticks <= 30;
        bit_idx <= bit_idx + 1;
      end
    end
    if (!owire_oe && oe_d) begin
      if (lw_n < 16) lw[lw_n] <= low_ticks;
      lw_n <= lw_n + 1;
      if (low_ticks >= 400 && sl_present) pd_delay <= 20;
    end
    if (host_wr) begin
      lw_n <= 0;
      if (host_addr == AW'(1 << SHIFT)) begin
        bit_idx  <= 0;
        cur_byte <= sl_byte;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_raw(input int addr, input int val);
    @(negedge clk);
    host_addr  = AW'(addr);
    host_wdata = 8'(val);
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic rd_raw(input int addr, output int val);
    @(negedge clk);
    host_addr = AW'(addr);
    host_rd   = 1'b1;
    @(negedge clk);
    host_rd   = 1'b0;
    val       = int'(host_rdata);
  endtask

  task automatic wr(input int ofs, input int val);
    wr_raw(ofs << SHIFT, val);
  endtask

  task automatic rd(input int ofs, output int val);
    rd_raw(ofs << SHIFT, val);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  function automatic int exp_irq(input int st, input int en);
    int act;
    act = ((st & en & 8'h3D) != 0) ? 1 : 0;
    return ((en & 2) != 0) ? act : 1 - act;
  endfunction

  function automatic int bad_widths(input logic [7:0] tx);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      int e;
      int d;
      e = tx[i] ? 6 : 60;
      d = lw[i] - e;
      if (d > 1 || d < -1) bad++;
    end
    return bad;
  endfunction

  int v;
  int s;
  int seed_val;
  logic [7:0] txb;
  logic [7:0] slb;
  logic [7:0] rx_a;

  initial begin
    host_addr  = '0;
    host_wr    = 1'b0;
    host_rd    = 1'b0;
    host_wdata = '0;
    rst_n      = 1'b0;
    seed_val   = $urandom(32'h5eed1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    rd(2, v); check("R6", "status after reset", v, 8'h0C);
    check("R8", "irq idle active-low", int'(irq), 1);
    rd(0, v); check("R9", "cmd reads line high", v, 8'h08);

    // divisor and address map
    wr(4, 8'hF5); rd(4, v); check("R12", "divisor readback", v, 8'h15);
    check("R12", "clk_div port", int'(clk_div), 8'h15);
    wr_raw(5 << SHIFT, 8'h3F); rd(4, v); check("R1", "unmapped write ignored", v, 8'h15);
    rd_raw(5 << SHIFT, v); check("R1", "unmapped read zero", v, 0);
    rd_raw(1, v); check("R1", "odd address read zero", v, 0);

    // bus reset, no device
    sl_present = 1'b0;
    wr(0, 8'h01);
    wait_ticks(100);
    rd(0, v); check("R2", "cmd busy during reset", v & 1, 1);
    wait_ticks(950);
    check("R2", "reset low width ok", (lw[0] >= 479 && lw[0] <= 481) ? 1 : 0, 1);
    rd(2, v); check("R2", "pd set, absent", v & 3, 3);
    rd(2, v); check("R7", "pd cleared, result kept", v & 8'h3F, 8'h0E);

    // bus reset, device present
    sl_present = 1'b1;
    wr(0, 8'h01);
    wait_ticks(1050);
    rd(0, v); check("R2", "cmd idle after reset", v & 1, 0);
    rd(2, v); check("R2", "pd set, present", v & 3, 1);

    // random bytes against random slave bytes
    for (int k = 0; k < 6; k++) begin
      txb = (k == 0) ? 8'hFF : 8'($urandom);
      slb = (k == 1) ? 8'hFF : 8'($urandom);
      sl_byte = slb;
      wr(1, txb);
      wait_ticks(20);
      rd(2, v); check("R6", "tbe set, tsre clear mid byte", v & 8'h0C, 8'h04);
      wait_ticks(520);
      check("R3", "slot low widths", bad_widths(txb), 0);
      rd(2, v); check("R4", "status after byte", v & 8'h3D, 8'h1C);
      rd(1, v); check("R4", "received byte", v, int'(txb & slb));
      rd(2, v); check("R4", "rbf cleared by data read", v & 8'h10, 0);
    end

    // second receive stage
    sl_byte = 8'h3C;
    wr(1, 8'hFF);
    wait_ticks(520);
    sl_byte = 8'hFF;
    wr(1, 8'h81);
    wait_ticks(520);
    rd(2, v); check("R5", "both stages full", v & 8'h3C, 8'h3C);
    rd(1, v); check("R5", "older byte first", v, 8'h3C);
    rd(2, v); check("R5", "second stage moved up", v & 8'h30, 8'h10);
    rd(1, v); check("R5", "newer byte", v, 8'h81);
    rd(2, v); check("R5", "buffers empty", v & 8'h30, 0);

    // interrupt: directed then random
    sl_byte = 8'hFF;
    wr(1, 8'h55);
    wait_ticks(520);
    wr(3, 8'h10); check("R8", "rbf irq active-low", int'(irq), 0);
    wr(3, 8'h12); check("R8", "rbf irq active-high", int'(irq), 1);
    rd(1, v);
    @(negedge clk); check("R8", "irq drops after read", int'(irq), 0);
    for (int k = 0; k < 8; k++) begin
      int en;
      en = int'($urandom) & 8'h3F;
      wr(3, en);
      rd(2, s);
      check("R8", "random enable irq", int'(irq), exp_irq(s, en));
    end
    wr(3, 0);

    // force low gating
    wr(0, 8'h04);
    repeat (3) @(negedge clk);
    check("R9", "force ignored when gated", int'(owire_oe), 0);
    wr(3, 8'h40);
    check("R9", "force drives line", int'(owire_oe), 1);
    repeat (3) @(negedge clk);
    rd(0, v); check("R9", "cmd shows line low, bit2 reads 0", v, 0);
    wr(0, 8'h00);
    wr(3, 8'h00);
    check("R9", "line released", int'(owire_oe), 0);

    // reset request ahead of pending byte
    sl_byte    = 8'hFF;
    sl_present = 1'b1;
    wr(0, 8'h01);
    wr(1, 8'hA5);
    wait_ticks(20);
    rd(2, v); check("R11", "byte held while reset runs", v & 8'h04, 0);
    rd(0, v); check("R11", "reset active first", v & 1, 1);
    wait_ticks(1600);
    rd(2, v); check("R11", "pd set, byte received", v & 8'h13, 8'h11);
    rd(1, v); check("R11", "byte after reset", v, 8'hA5);

    // software reset mid slot
    wr(3, 8'h5D);
    wr(4, 8'h07);
    wr(1, 8'h00);
    wait_ticks(10);
    check("R10", "line low in 0 slot", int'(owire_oe), 1);
    wr(0, 8'h20);
    check("R10", "line released after swrst", int'(owire_oe), 0);
    rd(2, v); check("R10", "status defaults", v, 8'h0C);
    rd(3, v); check("R10", "enable cleared", v, 0);
    rd(4, v); check("R10", "divisor cleared", v, 0);
    wait_ticks(100);
    check("R10", "line stays released", int'(owire_oe), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule